// File: doc/BRIEF.md
# Standby Low-Core-Voltage Monitor Handler

This block sits beside a hardware monitor that runs from a standby supply. An analog comparator, outside this block, reports when the processor core rail has fallen below its programmed low limit. When standby handling is enabled and that report arrives, the block does four things. It records the event in a sticky status bit. It raises an alert unless the alert is masked. It freezes the thermal-event timer and stops thermal-input monitoring. It also suspends dynamic minimum-temperature adjustment and blocks the shutdown path.

When the comparator reports that the rail is back above the limit, the gating enables return high and the timer resumes counting. The status bit stays set until a clear strobe arrives while the condition is absent. The comparator output is asynchronous to the block clock, so it passes through a synchronizer. The thermal input and the control bits are synchronous to the block clock.

Top module: `stby_lowcore_mon`

## Requirements
- R1: During and after reset, with no stimulus, `stat_lowcore` is 0, the alert is inactive, `therm_mon_en`, `dyn_tmin_en` and `shutdown_en` are 1, and `therm_count` is 0.
- R2: `core_low_raw` passes through SYNC_STAGES flip-flops (default 2). A rise of `core_low_raw` with `stby_en`=1 drops the gating enables after exactly SYNC_STAGES rising clock edges, and not after fewer.
- R3: While `stby_en` is 0, `core_low_raw` has no effect: the status stays 0 and all three gating enables stay 1.
- R4: The status bit becomes 1 one clock edge after the synchronized condition appears. It stays 1 after the rail recovers, until it is cleared.
- R5: A `stat_clr` pulse clears the status bit only when the condition is absent. If the condition is present in the same cycle as the clear, the set wins and the bit stays 1.
- R6: The alert is active exactly when the status bit is 1 and `alert_mask` is 0. Removing the mask raises the alert in the same cycle. With ALERT_LOW=0 the active level is 1.
- R7: While the condition holds, `therm_mon_en` is 0 and `therm_count` keeps the value it had on entry, whatever `therm_in` does.
- R8: While monitoring is enabled, `therm_count` increments once per clock edge at which `therm_in` is 1. It saturates at 2^TIMER_W-1.
- R9: While the condition holds, `dyn_tmin_en` and `shutdown_en` are 0. Exactly SYNC_STAGES edges after `core_low_raw` falls, all three enables return to 1 and the timer resumes counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_low_raw | input | 1 | Asynchronous comparator output: core rail below its low limit |
| stby_en | input | 1 | Standby handling enable bit |
| alert_mask | input | 1 | 1 masks the alert output |
| stat_clr | input | 1 | Status clear strobe |
| therm_in | input | 1 | Thermal event input, synchronous, active high |
| stat_lowcore | output | 1 | Sticky low-core-voltage status bit |
| alert_o | output | 1 | Alert output, polarity set by ALERT_LOW |
| therm_mon_en | output | 1 | Thermal-input monitoring enable |
| dyn_tmin_en | output | 1 | Dynamic minimum-temperature adjustment enable |
| shutdown_en | output | 1 | Shutdown path enable |
| therm_count | output | TIMER_W | Thermal timer value, held during the condition |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a status clear strobe and a live low-voltage condition. The bench holds `stat_clr` high across the edges at which the synchronized condition is still present and leaving. It expects the bit to survive those edges and to clear only on the first edge after the condition is gone. The second pair is the timer's count and the entry freeze. The bench keeps `therm_in` high while `core_low_raw` rises and falls. It judges the exact count: increments continue through the synchronizer edges on entry, stop while the condition holds, and resume one edge after the enables return.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
package stby_pkg;

   typedef struct packed {
      logic therm_mon;
      logic dyn_tmin;
      logic shdn;
   } stby_gate_t;

   function automatic stby_gate_t gates_for(input logic low_active);
      stby_gate_t g;
      g.therm_mon = ~low_active;
      g.dyn_tmin  = ~low_active;
      g.shdn      = ~low_active;
      return g;
   endfunction

endpackage

// File: rtl/stby_sync.sv
`timescale 1ns/1ps
module stby_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("stby_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stby_ctrl.sv
`timescale 1ns/1ps
module stby_ctrl
   import stby_pkg::*;
#(
   parameter bit ALERT_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       low_sync,
   input  logic       stby_en,
   input  logic       alert_mask,
   input  logic       stat_clr,
   output logic       cond_o,
   output logic       stat_o,
   output logic       alert_o,
   output stby_gate_t gate_o
);

   logic stat_q;
   logic alert_act;

   assign cond_o = low_sync & stby_en;
   assign gate_o = gates_for(cond_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= 1'b0;
      else if (cond_o) stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
   end

   assign stat_o    = stat_q;
   assign alert_act = stat_q & ~alert_mask;

   generate
      if (ALERT_LOW) begin : g_alert_lo
         assign alert_o = ~alert_act;
      end else begin : g_alert_hi
         assign alert_o = alert_act;
      end
   endgenerate

   AST_SET_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
      cond_o |=> stat_q);                                        // R4
   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !stat_clr) |=> stat_q);                         // R4
   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !cond_o) |=> !stat_q);                        // R5
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      alert_mask |-> (alert_o == ALERT_LOW));                    // R6

endmodule

// File: rtl/stby_therm_timer.sv
`timescale 1ns/1ps
module stby_therm_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               therm_in,
   input  logic               mon_en,
   output logic [TIMER_W-1:0] count_o
);

   generate
      if (TIMER_W < 2 || TIMER_W > 32) begin : g_bad
         $error("stby_therm_timer: TIMER_W out of range 2..32");
      end
   endgenerate

   localparam logic [TIMER_W-1:0] CNT_MAX = {TIMER_W{1'b1}};

   logic [TIMER_W-1:0] cnt_q;
   logic               step;

   assign step = therm_in & mon_en & (cnt_q != CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> $stable(cnt_q));                               // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));                // R8
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !therm_in |=> $stable(cnt_q));                             // R8

endmodule

// File: rtl/stby_lowcore_mon.sv
`timescale 1ns/1ps
module stby_lowcore_mon
   import stby_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TIMER_W     = 16,
   parameter bit ALERT_LOW   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               core_low_raw,
   input  logic               stby_en,
   input  logic               alert_mask,
   input  logic               stat_clr,
   input  logic               therm_in,
   output logic               stat_lowcore,
   output logic               alert_o,
   output logic               therm_mon_en,
   output logic               dyn_tmin_en,
   output logic               shutdown_en,
   output logic [TIMER_W-1:0] therm_count
);

   logic       low_sync;
   logic       cond;
   stby_gate_t gate;

   stby_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (core_low_raw),
      .q_sync  (low_sync)
   );

   stby_ctrl #(.ALERT_LOW(ALERT_LOW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .low_sync   (low_sync),
      .stby_en    (stby_en),
      .alert_mask (alert_mask),
      .stat_clr   (stat_clr),
      .cond_o     (cond),
      .stat_o     (stat_lowcore),
      .alert_o    (alert_o),
      .gate_o     (gate)
   );

   stby_therm_timer #(.TIMER_W(TIMER_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .therm_in (therm_in),
      .mon_en   (gate.therm_mon),
      .count_o  (therm_count)
   );

   assign therm_mon_en = gate.therm_mon;
   assign dyn_tmin_en  = gate.dyn_tmin;
   assign shutdown_en  = gate.shdn;

   AST_GATES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_mon_en == dyn_tmin_en) && (dyn_tmin_en == shutdown_en));   // R9
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_en |-> (therm_mon_en && shutdown_en));                     // R3
   AST_GATE_MARKS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      !shutdown_en |=> stat_lowcore);                                  // R4

endmodule

// File: tb/stby_lowcore_mon_test.sv
`timescale 1ns/1ps
module stby_lowcore_mon_test;

   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          core_low_raw = 1'b0;
   logic          stby_en = 1'b0;
   logic          alert_mask = 1'b0;
   logic          stat_clr = 1'b0;
   logic          therm_in = 1'b0;
   logic          stat_lowcore, alert_o, therm_mon_en, dyn_tmin_en, shutdown_en;
   logic [TW-1:0] therm_count;

   int checks = 0;
   int errors = 0;
   int exp_cnt = 0;

   always #2.5 clk = ~clk;

   stby_lowcore_mon #(.SYNC_STAGES(2), .TIMER_W(TW), .ALERT_LOW(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .core_low_raw(core_low_raw), .stby_en(stby_en),
      .alert_mask(alert_mask), .stat_clr(stat_clr), .therm_in(therm_in),
      .stat_lowcore(stat_lowcore), .alert_o(alert_o), .therm_mon_en(therm_mon_en),
      .dyn_tmin_en(dyn_tmin_en), .shutdown_en(shutdown_en), .therm_count(therm_count)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_gates(input string req, input int exp);
      chk(req, therm_mon_en, exp);
      chk(req, dyn_tmin_en, exp);
      chk(req, shutdown_en, exp);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      tick(3);
      chk("R1 status in reset", stat_lowcore, 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 status", stat_lowcore, 0);
      chk("R1 alert", alert_o, 0);
      chk_gates("R1 gates", 1);
      chk("R1 count", therm_count, 0);
   endtask

   task automatic test_entry_exit;
      stby_en = 1'b1;
      core_low_raw = 1'b1;
      tick(1);
      chk_gates("R2 after one edge", 1);
      tick(1);
      chk_gates("R2 R9 gated after two edges", 0);
      chk("R4 status lags by one edge", stat_lowcore, 0);
      tick(1);
      chk("R4 status set", stat_lowcore, 1);
      chk("R6 alert unmasked", alert_o, 1);
      core_low_raw = 1'b0;
      tick(1);
      chk_gates("R9 still gated one edge after fall", 0);
      tick(1);
      chk_gates("R9 restored", 1);
      chk("R4 sticky after recovery", stat_lowcore, 1);
      stat_clr = 1'b1;
      tick(1);
      stat_clr = 1'b0;
      chk("R5 cleared", stat_lowcore, 0);
      chk("R6 alert drops", alert_o, 0);
   endtask

   task automatic test_disabled;
      stby_en = 1'b0;
      core_low_raw = 1'b1;
      tick(4);
      chk("R3 status untouched", stat_lowcore, 0);
      chk_gates("R3 gates untouched", 1);
      core_low_raw = 1'b0;
      tick(3);
      stby_en = 1'b1;
      tick(1);
      chk("R3 no late effect", stat_lowcore, 0);
   endtask

   task automatic test_mask;
      alert_mask = 1'b1;
      core_low_raw = 1'b1;
      tick(4);
      chk("R6 status set under mask", stat_lowcore, 1);
      chk("R6 alert masked", alert_o, 0);
      alert_mask = 1'b0;
      #1;
      chk("R6 alert on unmask", alert_o, 1);
      core_low_raw = 1'b0;
      tick(3);
      stat_clr = 1'b1;
      tick(1);
      stat_clr = 1'b0;
      chk("R5 clear after mask test", stat_lowcore, 0);
   endtask

   task automatic test_timer;
      therm_in = 1'b1;
      tick(10);
      exp_cnt = 10;
      chk("R8 counts", therm_count, exp_cnt);
      core_low_raw = 1'b1;
      tick(2);
      exp_cnt += 2;
      chk("R7 R2 counts through sync edges", therm_count, exp_cnt);
      chk("R7 monitoring off", therm_mon_en, 0);
      tick(5);
      chk("R7 held", therm_count, exp_cnt);
      core_low_raw = 1'b0;
      tick(2);
      chk("R7 still held at exit edge", therm_count, exp_cnt);
      tick(1);
      exp_cnt += 1;
      chk("R9 counting resumes", therm_count, exp_cnt);
      therm_in = 1'b0;
      tick(3);
      chk("R8 idle no count", therm_count, exp_cnt);
      therm_in = 1'b1;
      tick(300);
      chk("R8 saturates", therm_count, (1 << TW) - 1);
      therm_in = 1'b0;
      stat_clr = 1'b1;
      tick(1);
      stat_clr = 1'b0;
      chk("R5 clear after timer test", stat_lowcore, 0);
   endtask

   task automatic test_collide;
      core_low_raw = 1'b1;
      tick(3);
      chk("R4 set again", stat_lowcore, 1);
      stat_clr = 1'b1;
      tick(1);
      chk("R5 set wins over clear", stat_lowcore, 1);
      core_low_raw = 1'b0;
      tick(2);
      chk("R5 clear on exit edge loses", stat_lowcore, 1);
      tick(1);
      chk("R5 clear once condition gone", stat_lowcore, 0);
      stat_clr = 1'b0;
      tick(1);
      chk("R5 stays clear", stat_lowcore, 0);
   endtask

   initial begin
      do_reset();
      test_entry_exit();
      test_disabled();
      test_mask();
      test_timer();
      test_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule